// File: doc/BRIEF.md
# Debug Watchpoint Register Bank

This block is the software-visible register file of a processor debug watchpoint unit. The unit has six instruction watchpoints and two data watchpoints. For each group the bank holds a control word, one address register per watchpoint and one count register per watchpoint. It also holds a status word whose bits are set by hit pulses from the comparison logic elsewhere in the unit. The comparison logic itself is not part of this block.

A simple synchronous bus reaches the bank. Each cycle it carries a byte offset, write and read strobes, a size code and write data. Read data and an error indication come back registered, one cycle after the strobe. Only full-word accesses to mapped, word-aligned offsets are accepted. Any other access is rejected: it changes nothing and is flagged with a short error code. A write to the status word clears the whole word, whatever data it carries.

Top module: `wpt_regbank`

## Requirements
- R1: After a synchronous active-high reset, every register reads zero, `bus_err` is low and `bus_rdata` is zero.
- R2: The control, address and count registers store a written 32-bit value and return it on read. Their byte offsets are: instruction control 0x000, instruction address k at 0x040+4k (k=0..5), instruction count k at 0x080+4k, data control 0x100, data address k at 0x140+4k (k=0..1), data count k at 0x180+4k.
- R3: `bus_rdata` carries the read value in the cycle after an accepted read strobe, and is zero in every other cycle.
- R4: A full-word write to the status word at offset 0x200 clears all of its bits, whatever the write data.
- R5: A high bit k of `hit_in` sets status bit k on the next clock, and the bit stays set until a status write. Bits 0 to 5 belong to the instruction watchpoints and bits 6 and 7 to the data watchpoints. Status bits 31:8 read zero.
- R6: When a hit bit and a status write arrive in the same cycle, that hit bit is set after the clear.
- R7: An access whose `bus_size` is not 2'b10 (word) is rejected with error code 2'b01. It changes no register, and a rejected read returns zero. The size encodings are 2'b00 byte, 2'b01 halfword, 2'b10 word and 2'b11 reserved.
- R8: A word access to an offset that is not word-aligned, lies in a gap between registers or lies beyond 0x200 is rejected with error code 2'b10. It changes no register.
- R9: An access that has both a bad size and an unmapped offset reports code 2'b01.
- R10: `bus_err` is high for exactly the cycle after a rejected access, and low after accepted accesses and idle cycles.
- R11: A write changes only the addressed register. All other registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 10 | Byte offset from the block base |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_size | input | 2 | Access size code |
| bus_wdata | input | 32 | Write data |
| hit_in | input | 8 | Watchpoint hit pulses, one per watchpoint |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | Registered rejection flag |
| bus_err_code | output | 2 | Rejection cause: 01 size, 10 unmapped |

## Verification
The assertions assume that the write and read strobes are never high in the same cycle. They also assume that a status write they check for clearing carries no simultaneous hit; the sticky-hit property covers the case where a hit does arrive. The directed bench keeps to these rules. It raises only one strobe per access, and it drives hits together with a status write only in the one scenario meant to test the precedence rule.

// File: rtl/wpt_pkg.sv
package wpt_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 10;
    localparam int WORD_W  = ADDR_W - 2;
    localparam int NUM_IW  = 6;
    localparam int NUM_DW  = 2;
    localparam int HIT_W   = NUM_IW + NUM_DW;
    localparam int IDX_W   = 3;

    localparam logic [WORD_W-1:0] W_ICTL  = 8'h00;
    localparam logic [WORD_W-1:0] W_IADDR = 8'h10;
    localparam logic [WORD_W-1:0] W_ICNT  = 8'h20;
    localparam logic [WORD_W-1:0] W_DCTL  = 8'h40;
    localparam logic [WORD_W-1:0] W_DADDR = 8'h50;
    localparam logic [WORD_W-1:0] W_DCNT  = 8'h60;
    localparam logic [WORD_W-1:0] W_STAT  = 8'h80;
    localparam logic [WORD_W-1:0] IW_CNT  = WORD_W'(NUM_IW);
    localparam logic [WORD_W-1:0] DW_CNT  = WORD_W'(NUM_DW);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } size_e;

    typedef enum logic [1:0] {
        ERR_NONE = 2'b00,
        ERR_SIZE = 2'b01,
        ERR_MAP  = 2'b10
    } err_e;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_ICTL,
        RG_IADDR,
        RG_ICNT,
        RG_DCTL,
        RG_DADDR,
        RG_DCNT,
        RG_STAT
    } region_e;

    typedef struct packed {
        region_e          region;
        logic [IDX_W-1:0] idx;
        err_e             err;
    } dec_t;

    function automatic logic in_group(logic [WORD_W-1:0] w,
                                      logic [WORD_W-1:0] base,
                                      logic [WORD_W-1:0] cnt);
        return (w >= base) && (w < base + cnt);
    endfunction

    // Size check precedes the address check: a bad size wins.
    function automatic dec_t decode_access(logic [ADDR_W-1:0] addr,
                                           logic [1:0] size);
        dec_t d;
        logic [WORD_W-1:0] w;
        w        = addr[ADDR_W-1:2];
        d.region = RG_NONE;
        d.idx    = '0;
        d.err    = ERR_NONE;
        if (size != SZ_WORD) begin
            d.err = ERR_SIZE;
        end else if (addr[1:0] != 2'b00) begin
            d.err = ERR_MAP;
        end else if (w == W_ICTL) begin
            d.region = RG_ICTL;
        end else if (in_group(w, W_IADDR, IW_CNT)) begin
            d.region = RG_IADDR;
            d.idx    = IDX_W'(w - W_IADDR);
        end else if (in_group(w, W_ICNT, IW_CNT)) begin
            d.region = RG_ICNT;
            d.idx    = IDX_W'(w - W_ICNT);
        end else if (w == W_DCTL) begin
            d.region = RG_DCTL;
        end else if (in_group(w, W_DADDR, DW_CNT)) begin
            d.region = RG_DADDR;
            d.idx    = IDX_W'(w - W_DADDR);
        end else if (in_group(w, W_DCNT, DW_CNT)) begin
            d.region = RG_DCNT;
            d.idx    = IDX_W'(w - W_DCNT);
        end else if (w == W_STAT) begin
            d.region = RG_STAT;
        end else begin
            d.err = ERR_MAP;
        end
        return d;
    endfunction

endpackage

// File: rtl/wpt_decode.sv
module wpt_decode
    import wpt_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output dec_t              dec
);
    always_comb begin
        dec = decode_access(addr, size);
    end
endmodule

// File: rtl/wpt_reg_array.sv
module wpt_reg_array
    import wpt_pkg::*;
#(
    parameter int N = 1,
    parameter int W = DATA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     rdata
);
    logic [W-1:0] regs [N];

    for (genvar g = 0; g < N; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (we && idx == IDX_W'(g)) begin
                regs[g] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < N; i++) begin
            if (idx == IDX_W'(i)) rdata = regs[i];
        end
    end
endmodule

// File: rtl/wpt_status.sv
module wpt_status
    import wpt_pkg::*;
#(
    parameter int W = HIT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic [W-1:0] hit,
    output logic [W-1:0] stat
);
    // New hits are ORed in after the clear so they survive it.
    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
        end else begin
            stat <= (clr ? '0 : stat) | hit;
        end
    end
endmodule

// File: rtl/wpt_regbank.sv
module wpt_regbank
    import wpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_size,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [HIT_W-1:0]  hit_in,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    output logic [1:0]        bus_err_code
);
    dec_t              dec;
    logic              access;
    logic              wr_ok;
    logic              rd_ok;
    logic [DATA_W-1:0] rd_ictl, rd_iaddr, rd_icnt;
    logic [DATA_W-1:0] rd_dctl, rd_daddr, rd_dcnt;
    logic [HIT_W-1:0]  stat_q;
    logic [DATA_W-1:0] rd_mux;

    wpt_decode u_dec (
        .addr (bus_addr),
        .size (bus_size),
        .dec  (dec)
    );

    assign access = bus_wr | bus_rd;
    assign wr_ok  = bus_wr && (dec.err == ERR_NONE);
    assign rd_ok  = bus_rd && (dec.err == ERR_NONE);

    wpt_reg_array #(.N(1)) u_ictl (
        .clk(clk), .rst(rst), .we(wr_ok && dec.region == RG_ICTL),
        .idx(dec.idx), .wdata(bus_wdata), .rdata(rd_ictl)
    );
    wpt_reg_array #(.N(NUM_IW)) u_iaddr (
        .clk(clk), .rst(rst), .we(wr_ok && dec.region == RG_IADDR),
        .idx(dec.idx), .wdata(bus_wdata), .rdata(rd_iaddr)
    );
    wpt_reg_array #(.N(NUM_IW)) u_icnt (
        .clk(clk), .rst(rst), .we(wr_ok && dec.region == RG_ICNT),
        .idx(dec.idx), .wdata(bus_wdata), .rdata(rd_icnt)
    );
    wpt_reg_array #(.N(1)) u_dctl (
        .clk(clk), .rst(rst), .we(wr_ok && dec.region == RG_DCTL),
        .idx(dec.idx), .wdata(bus_wdata), .rdata(rd_dctl)
    );
    wpt_reg_array #(.N(NUM_DW)) u_daddr (
        .clk(clk), .rst(rst), .we(wr_ok && dec.region == RG_DADDR),
        .idx(dec.idx), .wdata(bus_wdata), .rdata(rd_daddr)
    );
    wpt_reg_array #(.N(NUM_DW)) u_dcnt (
        .clk(clk), .rst(rst), .we(wr_ok && dec.region == RG_DCNT),
        .idx(dec.idx), .wdata(bus_wdata), .rdata(rd_dcnt)
    );

    wpt_status u_stat (
        .clk  (clk),
        .rst  (rst),
        .clr  (wr_ok && dec.region == RG_STAT),
        .hit  (hit_in),
        .stat (stat_q)
    );

    always_comb begin
        unique case (dec.region)
            RG_ICTL:  rd_mux = rd_ictl;
            RG_IADDR: rd_mux = rd_iaddr;
            RG_ICNT:  rd_mux = rd_icnt;
            RG_DCTL:  rd_mux = rd_dctl;
            RG_DADDR: rd_mux = rd_daddr;
            RG_DCNT:  rd_mux = rd_dcnt;
            RG_STAT:  rd_mux = DATA_W'(stat_q);
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata    <= '0;
            bus_err      <= 1'b0;
            bus_err_code <= ERR_NONE;
        end else begin
            bus_rdata    <= rd_ok ? rd_mux : '0;
            bus_err      <= access && (dec.err != ERR_NONE);
            bus_err_code <= access ? dec.err : ERR_NONE;
        end
    end
endmodule

// File: rtl/wpt_regbank_chk.sv
module wpt_regbank_chk
    import wpt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [1:0]        bus_size,
    input logic [HIT_W-1:0]  hit_in,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_err,
    input logic [1:0]        bus_err_code,
    input logic [HIT_W-1:0]  stat_q
);
    a_r1_reset_clean: assert property (@(posedge clk)
        rst |=> (!bus_err && bus_rdata == '0 && stat_q == '0));

    a_r4_status_cleared: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_size == 2'b10 && bus_addr == 10'h200 && hit_in == '0)
        |=> stat_q == '0);

    // R5 and R6: a hit bit is always present the cycle after it arrives.
    a_r5_hit_sticky: assert property (@(posedge clk) disable iff (rst)
        (hit_in != '0) |=> ((stat_q & $past(hit_in)) == $past(hit_in)));

    a_r5_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
        (hit_in == '0 && !bus_wr) |=> $stable(stat_q));

    a_r7_size_reject: assert property (@(posedge clk) disable iff (rst)
        ((bus_wr || bus_rd) && bus_size != 2'b10)
        |=> (bus_err && bus_err_code == 2'b01 && bus_rdata == '0));

    a_r8_misaligned: assert property (@(posedge clk) disable iff (rst)
        ((bus_wr || bus_rd) && bus_size == 2'b10 && bus_addr[1:0] != 2'b00)
        |=> (bus_err && bus_err_code == 2'b10 && bus_rdata == '0));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr || bus_rd) |=> (!bus_err && bus_rdata == '0));
endmodule

bind wpt_regbank wpt_regbank_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_size     (bus_size),
    .hit_in       (hit_in),
    .bus_rdata    (bus_rdata),
    .bus_err      (bus_err),
    .bus_err_code (bus_err_code),
    .stat_q       (stat_q)
);

// File: tb/wpt_regbank_tb.sv
module wpt_regbank_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NREG = 19;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_size = 2'b10;
    logic [31:0] bus_wdata = '0;
    logic [7:0]  hit_in = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [1:0]  bus_err_code;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wpt_regbank u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .hit_in(hit_in), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .bus_err_code(bus_err_code)
    );

    function automatic logic [9:0] reg_addr(int k);
        if (k == 0)  return 10'h000;
        if (k <= 6)  return 10'(10'h040 + 4*(k-1));
        if (k <= 12) return 10'(10'h080 + 4*(k-7));
        if (k == 13) return 10'h100;
        if (k <= 15) return 10'(10'h140 + 4*(k-14));
        if (k <= 17) return 10'(10'h180 + 4*(k-16));
        return 10'h200;
    endfunction

    function automatic logic [31:0] pattern(int k);
        return {8'(k), 8'hC3, ~8'(k), 8'h5A};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One access: drive at a falling edge, sample the registered reply at the next.
    task automatic access(logic [9:0] a, logic [1:0] sz, bit wr, bit rd,
                          logic [31:0] wd, logic [7:0] hit,
                          output logic [31:0] rdat, output logic err,
                          output logic [1:0] code);
        @(negedge clk);
        bus_addr = a; bus_size = sz; bus_wr = wr; bus_rd = rd;
        bus_wdata = wd; hit_in = hit;
        @(negedge clk);
        rdat = bus_rdata; err = bus_err; code = bus_err_code;
        bus_wr = 1'b0; bus_rd = 1'b0; hit_in = '0;
    endtask

    task automatic wr_word(logic [9:0] a, logic [31:0] d);
        logic [31:0] r; logic e; logic [1:0] c;
        access(a, 2'b10, 1, 0, d, 8'h00, r, e, c);
        check("R2 write accepted", {31'b0, e}, 32'd0);
    endtask

    task automatic rd_word(logic [9:0] a, output logic [31:0] r);
        logic e; logic [1:0] c;
        access(a, 2'b10, 0, 1, 32'h0, 8'h00, r, e, c);
    endtask

    task automatic t_reset;
        logic [31:0] r;
        check("R1 rdata after reset", bus_rdata, 32'h0);
        check("R1 err after reset", {31'b0, bus_err}, 32'h0);
        for (int k = 0; k < NREG; k++) begin
            rd_word(reg_addr(k), r);
            check("R1 register zero", r, 32'h0);
        end
    endtask

    task automatic t_readwrite;
        logic [31:0] r;
        for (int k = 0; k < NREG - 1; k++) wr_word(reg_addr(k), pattern(k));
        for (int k = 0; k < NREG - 1; k++) begin
            rd_word(reg_addr(k), r);
            check("R2 R11 readback", r, pattern(k));
        end
        @(negedge clk);
        check("R3 rdata zero when idle", bus_rdata, 32'h0);
    endtask

    task automatic t_size;
        logic [31:0] r; logic e; logic [1:0] c;
        for (int s = 0; s < 4; s++) begin
            if (s == 2) continue;
            access(reg_addr(9), 2'(s), 1, 0, 32'hDEAD_BEEF, 8'h00, r, e, c);
            check("R7 size write err", {30'b0, e, 1'b0} | {30'b0, c}, 32'h3);
            access(reg_addr(9), 2'(s), 0, 1, 32'h0, 8'h00, r, e, c);
            check("R7 size read returns zero", r, 32'h0);
            check("R7 size read code", {30'b0, c}, 32'h1);
        end
        rd_word(reg_addr(9), r);
        check("R7 register unchanged", r, pattern(9));
        @(negedge clk);
        check("R10 err drops after reject", {31'b0, bus_err}, 32'h0);
    endtask

    task automatic t_unmapped;
        logic [31:0] r; logic e; logic [1:0] c;
        logic [9:0] gaps [6] = '{10'h004, 10'h058, 10'h148, 10'h204, 10'h3FC, 10'h041};
        foreach (gaps[i]) begin
            access(gaps[i], 2'b10, 1, 0, 32'hFFFF_FFFF, 8'h00, r, e, c);
            check("R8 unmapped write err", {31'b0, e}, 32'h1);
            check("R8 unmapped write code", {30'b0, c}, 32'h2);
            access(gaps[i], 2'b10, 0, 1, 32'h0, 8'h00, r, e, c);
            check("R8 unmapped read zero", r, 32'h0);
        end
        for (int k = 0; k < NREG - 1; k++) begin
            rd_word(reg_addr(k), r);
            check("R8 R11 no side effect", r, pattern(k));
        end
    endtask

    task automatic t_priority;
        logic [31:0] r; logic e; logic [1:0] c;
        access(10'h006, 2'b00, 1, 0, 32'h1, 8'h00, r, e, c);
        check("R9 size beats address", {30'b0, c}, 32'h1);
        access(10'h3F0, 2'b11, 0, 1, 32'h0, 8'h00, r, e, c);
        check("R9 size beats address read", {30'b0, c}, 32'h1);
        access(reg_addr(0), 2'b10, 0, 1, 32'h0, 8'h00, r, e, c);
        check("R10 no err on good access", {31'b0, e}, 32'h0);
    endtask

    task automatic t_status;
        logic [31:0] r; logic e; logic [1:0] c;
        access(10'h000, 2'b10, 0, 0, 32'h0, 8'h21, r, e, c);
        rd_word(10'h200, r);
        check("R5 hit sets bits", r, 32'h21);
        access(10'h000, 2'b10, 0, 0, 32'h0, 8'h80, r, e, c);
        rd_word(10'h200, r);
        check("R5 hits sticky", r, 32'hA1);
        access(10'h200, 2'b00, 1, 0, 32'h0, 8'h00, r, e, c);
        rd_word(10'h200, r);
        check("R7 bad size leaves status", r, 32'hA1);
        wr_word(10'h200, 32'h0000_0000);
        rd_word(10'h200, r);
        check("R4 status cleared by zero write", r, 32'h0);
        access(10'h000, 2'b10, 0, 0, 32'h0, 8'h42, r, e, c);
        wr_word(10'h200, 32'h1234_5678);
        rd_word(10'h200, r);
        check("R4 status cleared any data", r, 32'h0);
        access(10'h000, 2'b10, 0, 0, 32'h0, 8'h13, r, e, c);
        access(10'h200, 2'b10, 1, 0, 32'hFFFF_FFFF, 8'h04, r, e, c);
        rd_word(10'h200, r);
        check("R6 hit wins over clear", r, 32'h04);
        rd_word(reg_addr(3), r);
        check("R11 status ops leave others", r, pattern(3));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_readwrite();
        t_size();
        t_unmapped();
        t_priority();
        t_status();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule